// File: doc/BRIEF.md
# Context Segmented Page MMU

This block translates virtual addresses from a 16-bit processor bus into physical word addresses. Translation walks two tables. A segment map, indexed by the hardware context and the top nine virtual address bits, gives an 8-bit group number. That group number selects 16 consecutive page entries in one shared page map. The page entry supplies a 20-bit physical page number, an address-space type and a valid bit. Every translated access sets the entry's accessed bit. A valid write also sets its modified bit. An access through an invalid entry raises a fault.

Software programs the block through control-space accesses. These read and write the context register, the segment map and the page map. Both map accesses go through the current user context. A page entry can therefore only be loaded after the segment entry that points at its group has been set. The supervisor or user context is chosen by function-code bit 2. When a type-1 translation lands in the 2 KB boot-ROM page, the block also flags a ROM hit. In that case it provides a ROM word address taken from the untranslated virtual bits, so the full 32 KB ROM can be seen through that one page.

Top module: `ctxmmu`

## Requirements
- R1: The context register is read and written in control space when addr[3:2] = 2'b10. It resets to 0. Its bits 10:8 name the supervisor context and bits 2:0 the user context. A translation with fc_sup = 1 uses the supervisor context; one with fc_sup = 0 uses the user context.
- R2: A control write with addr[3:2] = 2'b01 stores wdata[7:0] in the segment entry of the user context at addr[23:15]. A control read at the same select returns that entry zero-extended to 16 bits.
- R3: A translation indexes the page map with (segment entry × 16 + addr[14:11]). It outputs pa = {entry[19:0], addr[10:1]} as a word address.
- R4: Page-map control accesses use addr[3:2] = 2'b00 and reach the entry chosen through the user context's segment map. addr[1] = 1 carries entry bits 15:0, and addr[1] = 0 carries entry bits 31:16.
- R5: Entry bit 31 is the valid bit. A translation through a valid entry raises xlat_ok and drives space with entry bits 24:22.
- R6: Every translation, valid or not, sets entry bit 21 (accessed). The change is visible to a control read in the following cycle.
- R7: Entry bit 20 (modified) is set only by a write translation through a valid entry. A read translation leaves it unchanged.
- R8: A translation through an invalid entry raises fault for the cycle of that access only and holds xlat_ok low. A write of this kind leaves the modified bit unchanged.
- R9: rom_hit is raised when a valid translation has space type 1 and physical page number ROM_PPN (0xFE0 by default). It then drives rom_addr with the original addr[14:1]. Other space types and pages leave rom_hit low.
- R10: Control-space accesses perform no translation: fault stays low, and the accessed and modified bits are not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_ctl | input | 1 | 1: control-space access, 0: translated access |
| acc_write | input | 1 | 1: write, 0: read |
| fc_sup | input | 1 | Function-code bit 2, selects the supervisor context |
| addr | input | 23 | Virtual word address, byte-address bits 23:1 |
| wdata | input | 16 | Control write data |
| rdata | output | 16 | Control read data |
| xlat_ok | output | 1 | Valid translation this cycle |
| fault | output | 1 | Invalid-page fault this cycle |
| pa | output | 30 | Physical word address |
| space | output | 3 | Address-space type |
| rom_hit | output | 1 | Translation falls in the boot-ROM window |
| rom_addr | output | 14 | ROM word address from the virtual bits |

## Verification
The tests run translations with both function-code settings while the supervisor and user contexts point to different segment entries for the same virtual address. A correct result therefore shows that the right context was chosen. The same page is accessed with reads, with writes, and in its invalid state. This separates setting the accessed bit from setting the modified bit, and shows the fault that must leave the modified bit unchanged. ROM-window cases vary the space type and the physical page one at a time, so a rom_hit that ignores either condition shows up. Readback through control space after each translation shows what it changed and what it left alone.

// File: rtl/ctxmmu.sv
`timescale 1ns/1ps
module ctxmmu #(
  parameter int VA_W     = 24,
  parameter int PAGE_W   = 11,
  parameter int GRP_W    = 4,
  parameter int PMEG_W   = 8,
  parameter int CTX_W    = 3,
  parameter int PPN_W    = 20,
  parameter int ROM_AW   = 14,
  parameter logic [19:0] ROM_PPN = 20'hFE0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_ctl,
  input  logic                       acc_write,
  input  logic                       fc_sup,
  input  logic [VA_W-1:1]            addr,
  input  logic [15:0]                wdata,
  output logic [15:0]                rdata,
  output logic                       xlat_ok,
  output logic                       fault,
  output logic [PPN_W+PAGE_W-2:0]    pa,
  output logic [2:0]                 space,
  output logic                       rom_hit,
  output logic [ROM_AW-1:0]          rom_addr
);
  localparam int SEG_W = VA_W - PAGE_W - GRP_W;
  localparam int SM_N  = 1 << (CTX_W + SEG_W);
  localparam int PI_W  = PMEG_W + GRP_W;
  localparam int PM_N  = 1 << PI_W;
  localparam int B_VLD = 31;
  localparam int B_ACC = 21;
  localparam int B_MOD = 20;

  logic [PMEG_W-1:0] segmap  [SM_N];
  logic [31:0]       pagemap [PM_N];
  logic [15:0]       ctx_reg;

  wire [CTX_W-1:0] ctx_s = ctx_reg[8 +: CTX_W];
  wire [CTX_W-1:0] ctx_u = ctx_reg[0 +: CTX_W];
  wire [SEG_W-1:0] seg_idx = addr[VA_W-1 -: SEG_W];
  wire [GRP_W-1:0] grp_off = addr[PAGE_W +: GRP_W];
  wire [1:0]       ctl_sel = addr[3:2];

  wire ctl_acc = acc_valid & acc_ctl;
  wire xlat    = acc_valid & ~acc_ctl;

  wire [CTX_W-1:0]  use_ctx = (xlat && fc_sup) ? ctx_s : ctx_u;
  wire [PMEG_W-1:0] seg_ent = segmap[{use_ctx, seg_idx}];
  wire [PI_W-1:0]   pidx    = {seg_ent, grp_off};
  wire [31:0]       pte     = pagemap[pidx];

  assign xlat_ok  = xlat & pte[B_VLD];
  assign fault    = xlat & ~pte[B_VLD];
  assign pa       = {pte[PPN_W-1:0], addr[PAGE_W-1:1]};
  assign space    = pte[24:22];
  assign rom_hit  = xlat_ok && (space == 3'd1) && (pte[PPN_W-1:0] == ROM_PPN);
  assign rom_addr = addr[ROM_AW:1];

  always_comb begin
    rdata = '0;
    if (ctl_acc) begin
      case (ctl_sel)
        2'b00:   rdata = addr[1] ? pte[15:0] : pte[31:16];
        2'b01:   rdata = 16'(seg_ent);
        2'b10:   rdata = ctx_reg;
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctx_reg <= '0;
    else if (ctl_acc && acc_write && ctl_sel == 2'b10) ctx_reg <= wdata;
  end

  always_ff @(posedge clk) begin
    if (ctl_acc && acc_write && ctl_sel == 2'b01)
      segmap[{ctx_u, seg_idx}] <= wdata[PMEG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (ctl_acc && acc_write && ctl_sel == 2'b00) begin
      if (addr[1]) pagemap[pidx][15:0]  <= wdata;
      else         pagemap[pidx][31:16] <= wdata;
    end else if (xlat) begin
      pagemap[pidx][B_ACC] <= 1'b1;
      if (acc_write && pte[B_VLD]) pagemap[pidx][B_MOD] <= 1'b1;
    end
  end

  AST_CTX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc && acc_write && ctl_sel == 2'b10) |=> ctx_reg == $past(wdata)); // R1
  AST_SEG_LOW8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc && acc_write && ctl_sel == 2'b01)
      |=> segmap[$past({ctx_u, seg_idx})] == $past(wdata[PMEG_W-1:0])); // R2
  AST_ACC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |=> pagemap[$past(pidx)][B_ACC]); // R6
  AST_MOD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_ok && acc_write) |=> pagemap[$past(pidx)][B_MOD]); // R7
  AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || (xlat && !acc_write))
      |=> pagemap[$past(pidx)][B_MOD] == $past(pte[B_MOD])); // R8
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault, xlat_ok})); // R8
  AST_ROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> !fault); // R9
  AST_CTL_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ctl |-> !fault); // R10
endmodule

// File: tb/ctxmmu_tb.sv
`timescale 1ns/1ps
module ctxmmu_tb_top;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_ctl = 0, acc_write = 0, fc_sup = 0;
  logic [23:1] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic xlat_ok, fault, rom_hit;
  logic [29:0] pa;
  logic [2:0] space;
  logic [13:0] rom_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] s_rd; logic s_ok, s_flt, s_rom; logic [29:0] s_pa; logic [2:0] s_sp; logic [13:0] s_ra;

  always #4 clk = ~clk;

  ctxmmu dut_i (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ctl(acc_ctl),
    .acc_write(acc_write), .fc_sup(fc_sup), .addr(addr), .wdata(wdata), .rdata(rdata),
    .xlat_ok(xlat_ok), .fault(fault), .pa(pa), .space(space), .rom_hit(rom_hit),
    .rom_addr(rom_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(bit ctl, bit wr, bit sup, logic [23:0] ba, logic [15:0] d);
    @(negedge clk);
    acc_valid = 1; acc_ctl = ctl; acc_write = wr; fc_sup = sup; addr = ba[23:1]; wdata = d;
    #2;
    s_rd = rdata; s_ok = xlat_ok; s_flt = fault; s_rom = rom_hit; s_pa = pa; s_sp = space; s_ra = rom_addr;
    @(posedge clk); #1;
    acc_valid = 0; acc_ctl = 0; acc_write = 0;
  endtask

  // control select in byte address bits 3:2, page half in bit 1
  task automatic set_ctx(logic [15:0] v); op(1, 1, 0, 24'h8, v); endtask
  task automatic set_seg(logic [23:0] ba, logic [15:0] v); op(1, 1, 0, ba | 24'h4, v); endtask
  task automatic set_pte(logic [23:0] ba, logic [15:0] hi, logic [15:0] lo);
    op(1, 1, 0, ba, hi); op(1, 1, 0, ba | 24'h2, lo);
  endtask
  task automatic pte_hi(logic [23:0] ba); op(1, 0, 0, ba, 16'h0); endtask

  task automatic t_reset;
    op(1, 0, 0, 24'h8, 0); chk("R1 ctx reset", s_rd, 16'h0);
    chk("R10 no fault on ctl", s_flt, 0);
  endtask

  task automatic t_load;
    set_ctx(16'h0301);
    op(1, 0, 0, 24'h8, 0); chk("R1 ctx readback", s_rd, 16'h0301);
    set_seg(24'h008000, 16'h01A5);
    op(1, 0, 0, 24'h008004, 0); chk("R2 seg low 8 bits", s_rd, 16'h00A5);
    set_pte(24'h009000, 16'h8001, 16'h2345);
    pte_hi(24'h009000); chk("R4 high half", s_rd, 16'h8001);
    chk("R10 ctl leaves status", s_rd[5:4], 2'b00);
    op(1, 0, 0, 24'h009002, 0); chk("R4 low half", s_rd, 16'h2345);
    set_pte(24'h008800, 16'h0000, 16'h0000);
  endtask

  task automatic t_translate;
    op(0, 0, 0, 24'h0097FE, 0);
    chk("R5 xlat_ok", s_ok, 1); chk("R8 no fault", s_flt, 0);
    chk("R3 pa", s_pa, {20'h12345, 10'h3FF}); chk("R5 space", s_sp, 3'd0);
    chk("R9 no rom type0", s_rom, 0);
    pte_hi(24'h009000); chk("R6 accessed after read", s_rd, 16'h8021);
    chk("R7 read leaves modified", s_rd[4], 0);
    op(0, 1, 0, 24'h009000, 0);
    pte_hi(24'h009000); chk("R7 modified after write", s_rd, 16'h8031);
  endtask

  task automatic t_super_rom;
    logic [23:0] va; va = 24'h008ABC;
    set_ctx(16'h0303);
    set_seg(24'h008000, 16'h0007);
    set_pte(24'h008800, 16'h8040, 16'h0FE0);
    set_ctx(16'h0301);
    op(0, 0, 1, va, 0);
    chk("R1 sup ctx valid", s_ok, 1); chk("R5 space type1", s_sp, 3'd1);
    chk("R3 pa sup", s_pa, {20'hFE0, va[10:1]});
    chk("R9 rom hit", s_rom, 1); chk("R9 rom addr", s_ra, va[14:1]);
    op(0, 1, 0, va, 0);
    chk("R1 user ctx differs", s_ok, 0); chk("R8 fault", s_flt, 1);
    @(negedge clk); #2; chk("R8 fault one cycle", fault, 0);
    op(1, 0, 0, 24'h008800, 0);
    chk("R8 modified unchanged, R6 accessed", s_rd, 16'h0020);
    chk("R10 ctl no fault on invalid", s_flt, 0);
    set_ctx(16'h0303);
    op(1, 1, 0, 24'h008802, 16'h0FE1);
    set_ctx(16'h0301);
    op(0, 0, 1, va, 0); chk("R9 other page no hit", s_rom, 0); chk("R9 ok", s_ok, 1);
    set_ctx(16'h0303);
    set_pte(24'h008800, 16'h8080, 16'h0FE0);
    set_ctx(16'h0301);
    op(0, 0, 1, va, 0); chk("R9 type2 no hit", s_rom, 0); chk("R5 space type2", s_sp, 3'd2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_load; t_translate; t_super_rom;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule